// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a host-paced SPI master that is reached through three 16-bit registers: a data register, a control register and a status register. The host fills the control register once with the enable, the word size, the clock mode, the clock divider and two interrupt enables. After that, every write to the data register sends one word of 8 or 16 bits MSB first on MOSI. In the same exchange it shifts a word in from MISO.

When the last bit has been taken in, the received word is placed in the data register and a receive-full flag is raised. Reading the data register takes the word and drops the flag. There is a single word of buffering and no chip-select generation. To receive without sending, the host writes zero to the data register.

SCLK toggles once every divider+1 peripheral clock cycles, which gives a serial rate of f/(2·(divider+1)). One interrupt line combines a read source and a write source. The read source fires on a full receive buffer. The write source fires when the module is enabled and ready for the next word.

Top module: `spi_host_master`

## Requirements
- R1: After reset the control and status registers read 0, SCLK and MOSI are low and the interrupt output is low.
- R2: The registers sit at byte offsets 0x0 (data), 0x2 (control) and 0x4 (status). Control bits 1, 3 and 4 read back as zero, and every other control bit reads back as written. Status bit 0 is busy, status bit 1 is receive-full, and the other status bits read zero.
- R3: A data write while enabled (control bit 0) and not busy starts one exchange. Control bit 2 selects 16-bit words when set and 8-bit words when clear. Busy stays high for exactly 2·N·(D+1) cycles, where N is the word length and D is control bits 15:9.
- R4: MOSI carries the written word MSB first. In 8-bit mode only bits 7:0 of the written word are sent.
- R5: Control bit 7 sets the SCLK idle level. With control bit 8 clear, MISO is sampled on the leading SCLK edge and MOSI changes on the trailing edge. With bit 8 set, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R6: At the end of an exchange the received word is readable at the data offset, right-aligned with zero upper bits in 8-bit mode, and receive-full reads 1.
- R7: A read of the data register clears receive-full on the following cycle, unless an exchange completes on that same cycle.
- R8: A data write while busy or while disabled has no effect on the exchange in progress or on the status.
- R9: Clearing the enable bit in the middle of an exchange ends it. Busy drops, SCLK returns to its idle level, MOSI goes low and receive-full stays clear.
- R10: The interrupt output is high exactly when (control bit 5 and receive-full) or (control bit 6, enabled and not busy).
- R11: While the module is disabled, SCLK equals control bit 7 and MOSI is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Host access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, combinational from the address |
| irq | output | 1 | Combined read/write interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: 16-bit register words and a 7-bit divider. It sweeps all four clock modes against both word sizes and dividers 0, 1 and 5, and also runs the largest divider, 127. A bus-level slave model in the bench drives MISO on its own shift edges and captures MOSI on its own sample edges. This lets the MOSI order, the MISO sampling and the exact length of every exchange be checked against arithmetic in the bench. Separate sequences cover writes that are ignored, an abort in mid-word, and each combination of interrupt sources.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int WORD_W = 16;
  localparam int HALF_W = WORD_W / 2;

  // byte offsets of the three host registers
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_CTL  = 3'd2;
  localparam logic [2:0] OFS_STAT = 3'd4;

  // control field positions (software depends on these)
  localparam int B_EN    = 0;
  localparam int B_WIDE  = 2;
  localparam int B_RDIE  = 5;
  localparam int B_WRIE  = 6;
  localparam int B_CPOL  = 7;
  localparam int B_CPHA  = 8;
  localparam int B_DIV   = 9;
  localparam logic [WORD_W-1:0] CTL_MASK = 16'hFFE5;

  function automatic int unsigned word_bits(input logic wide);
    return wide ? WORD_W : HALF_W;
  endfunction

  function automatic int unsigned word_edges(input logic wide);
    return 2 * word_bits(wide);
  endfunction
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int EDGE_W = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic              wide,
  input  logic              cpha,
  input  logic              tick,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              busy,
  output logic              mosi_bit,
  output logic              phase,
  output logic [DATA_W-1:0] rx_word,
  output logic              done,
  output logic [EDGE_W-1:0] edge_idx
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] tx_q, rx_q;
  logic [EDGE_W-1:0] last_edge;
  logic              sample_now, shift_now;

  assign last_edge  = EDGE_W'(word_edges(wide) - 1);
  assign sample_now = busy && tick && (edge_idx[0] == cpha);
  assign shift_now  = busy && tick && (edge_idx[0] != cpha) && (edge_idx != '0);
  assign done       = en && busy && tick && (edge_idx == last_edge);
  assign rx_word    = sample_now ? {rx_q[DATA_W-2:0], miso} : rx_q;
  assign mosi_bit   = tx_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; phase <= 1'b0; edge_idx <= '0; tx_q <= '0; rx_q <= '0;
    end else if (!en) begin
      busy <= 1'b0; phase <= 1'b0; edge_idx <= '0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      phase    <= 1'b0;
      edge_idx <= '0;
      rx_q     <= '0;
      tx_q     <= wide ? tx_word : {tx_word[HALF-1:0], {HALF{1'b0}}};
    end else if (busy && tick) begin
      phase <= ~phase;
      rx_q  <= rx_word;
      if (shift_now) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      if (edge_idx == last_edge) begin
        busy     <= 1'b0;
        edge_idx <= '0;
      end else begin
        edge_idx <= edge_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_host_master.sv
module spi_host_master
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 7,
  parameter int ADDR_W = 3,
  localparam int EDGE_W = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] ctl_q, rx_data_q, rx_word;
  logic              rx_full_q;
  logic              wr_data, rd_data, wr_ctl, start;
  logic              busy, mosi_bit, phase, done, tick;
  logic [EDGE_W-1:0] edge_idx;
  logic              en, wide, rd_ie, wr_ie, cpol, cpha;
  logic [DIV_W-1:0]  div;

  assign en    = ctl_q[B_EN];
  assign wide  = ctl_q[B_WIDE];
  assign rd_ie = ctl_q[B_RDIE];
  assign wr_ie = ctl_q[B_WRIE];
  assign cpol  = ctl_q[B_CPOL];
  assign cpha  = ctl_q[B_CPHA];
  assign div   = ctl_q[B_DIV +: DIV_W];

  assign wr_data = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
  assign rd_data = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
  assign wr_ctl  = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(OFS_CTL));
  assign start   = wr_data && en && !busy;

  spi_clk_div #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst_n(rst_n), .run(busy && en), .div(div), .tick(tick)
  );

  spi_shift_engine #(.DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .wide(wide),
    .cpha(cpha), .tick(tick), .tx_word(bus_wdata), .miso(miso),
    .busy(busy), .mosi_bit(mosi_bit), .phase(phase), .rx_word(rx_word),
    .done(done), .edge_idx(edge_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      rx_data_q <= '0;
      rx_full_q <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= bus_wdata & CTL_MASK;
      if (done) begin
        rx_data_q <= wide ? rx_word : {{HALF{1'b0}}, rx_word[HALF-1:0]};
        rx_full_q <= 1'b1;
      end else if (rd_data) begin
        rx_full_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_DATA): bus_rdata = rx_data_q;
      ADDR_W'(OFS_CTL):  bus_rdata = ctl_q;
      ADDR_W'(OFS_STAT): bus_rdata = {{(DATA_W-2){1'b0}}, rx_full_q, busy};
      default:           bus_rdata = '0;
    endcase
  end

  assign sclk = cpol ^ (phase && en);
  assign mosi = en && busy && mosi_bit;
  assign irq  = (rd_ie && rx_full_q) || (wr_ie && en && !busy);
endmodule

// File: rtl/spi_host_master_chk.sv
module spi_host_master_chk #(
  parameter int EDGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              cpol,
  input logic              rd_ie,
  input logic              wr_ie,
  input logic              busy,
  input logic              rx_full,
  input logic              tick,
  input logic              sclk,
  input logic              mosi,
  input logic              irq,
  input logic              wr_data,
  input logic              rd_data,
  input logic              wr_ctl,
  input logic              done,
  input logic [EDGE_W-1:0] edge_idx
);
  assert_idle_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (sclk == cpol) && !mosi);

  assert_sclk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en && busy && !tick && !wr_ctl |=> $stable(sclk));

  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en && busy && wr_data && !wr_ctl |=>
      (edge_idx == $past(edge_idx)) || (edge_idx == $past(edge_idx) + 1'b1) || !busy);

  assert_done_sets_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_full && !busy);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && !done |=> !rx_full);

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |=> !busy);

  assert_irq_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ie && rx_full |-> irq);

  assert_irq_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ie && en && !busy |-> irq);

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ie && !(wr_ie && en) |-> !irq);
endmodule

bind spi_host_master spi_host_master_chk #(.EDGE_W(EDGE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .rd_ie(rd_ie),
  .wr_ie(wr_ie), .busy(busy), .rx_full(rx_full_q), .tick(tick),
  .sclk(sclk), .mosi(mosi), .irq(irq), .wr_data(wr_data),
  .rd_data(rd_data), .wr_ctl(wr_ctl), .done(done), .edge_idx(edge_idx)
);

// File: tb/spi_host_master_tb.sv
module spi_host_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_DATA = 3'd0, A_CTL = 3'd2, A_STAT = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, sclk, mosi, miso;

  int n_checks = 0;
  int n_fail = 0;

  // slave model state
  logic        miso_r = 1'b0;
  int          arm_seq = 0, arm_seen = 0;
  logic [15:0] rsp_word = '0;
  int          nbits = 8;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [15:0] cap = '0;
  int          idx = 0;
  logic        sclk_prev = 1'b0, mosi_prev = 1'b0;

  assign miso = miso_r;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_host_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // SPI slave: shifts MISO on its change edges, captures MOSI on sample edges
  always @(negedge clk) begin
    if (arm_seq != arm_seen) begin
      arm_seen = arm_seq;
      cap = '0;
      if (!cfg_cpha) begin miso_r = rsp_word[nbits-1]; idx = nbits - 2; end
      else begin miso_r = 1'b0; idx = nbits - 1; end
    end else if (sclk !== sclk_prev) begin
      if ((sclk != cfg_cpol) != cfg_cpha) cap = {cap[14:0], mosi_prev};
      else begin
        if (idx >= 0) miso_r = rsp_word[idx];
        idx = idx - 1;
      end
    end
    sclk_prev = sclk;
    mosi_prev = mosi;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // called at a negedge: counts cycles with busy set, returns last status
  task automatic wait_busy(output int n, output logic [15:0] st);
    n = 0;
    for (int k = 0; k < 20000; k++) begin
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_STAT;
      #1 st = bus_rdata;
      if (!st[0]) break;
      n++;
      @(negedge clk);
    end
    bus_sel = 1'b0;
  endtask

  function automatic logic [15:0] ctl_word(input int mode, input bit wide,
                                           input int dv, input bit en,
                                           input bit rie, input bit wie);
    logic [15:0] w;
    w = 16'(dv) << 9;
    w[0] = en; w[2] = wide; w[5] = rie; w[6] = wie;
    w[7] = mode[1]; w[8] = mode[0];
    return w;
  endfunction

  task automatic arm(input int mode, input bit wide, input logic [15:0] rsp);
    cfg_cpol = mode[1]; cfg_cpha = mode[0];
    nbits = wide ? 16 : 8;
    rsp_word = rsp;
    arm_seq++;
  endtask

  task automatic xfer(input int mode, input bit wide, input int dv,
                      input logic [15:0] tx, input logic [15:0] rsp);
    int n; logic [15:0] st, d, mask;
    mask = wide ? 16'hFFFF : 16'h00FF;
    bus_write(A_CTL, ctl_word(mode, wide, dv, 1'b1, 1'b0, 1'b0));
    #1 check(sclk == mode[1], "R5 idle level", sclk, mode[1]);
    arm(mode, wide, rsp);
    bus_write(A_DATA, tx);
    wait_busy(n, st);
    check(n == 2 * (wide ? 16 : 8) * (dv + 1), "R3 exchange length", n,
          2 * (wide ? 16 : 8) * (dv + 1));
    check((cap & mask) == (tx & mask), "R4/R5 MOSI word", cap & mask, tx & mask);
    check(st[1] == 1'b1, "R6 receive-full set", st, 2);
    bus_read(A_DATA, d);
    check(d == (rsp & mask), "R6 received word", d, rsp & mask);
    bus_read(A_STAT, st);
    check(st[1] == 1'b0, "R7 read clears full", st, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] d, st, tx, rsp;
    int n, k;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sclk == 0 && mosi == 0 && irq == 0, "R1 pins at reset",
          {sclk, mosi, irq}, 0);
    rst_n = 1'b1;
    bus_read(A_CTL, d);  check(d == 16'h0, "R1 control reset", d, 0);
    bus_read(A_STAT, d); check(d == 16'h0, "R1 status reset", d, 0);

    // R2 control readback with reserved bits
    bus_write(A_CTL, 16'hFFFF);
    bus_read(A_CTL, d); check(d == 16'hFFE5, "R2 control readback", d, 16'hFFE5);
    bus_write(A_CTL, 16'h0000);
    bus_read(A_STAT, d); check(d == 16'h0, "R2 status unused bits", d, 0);

    // R11 / R8 disabled: idle high clock, write ignored
    bus_write(A_CTL, 16'h0080);
    #1 check(sclk == 1 && mosi == 0, "R11 disabled lines", {sclk, mosi}, 2);
    bus_write(A_DATA, 16'hFFFF);
    repeat (3) @(negedge clk);
    #1 check(sclk == 1 && mosi == 0, "R11 lines after data write", {sclk, mosi}, 2);
    bus_read(A_STAT, d); check(d == 16'h0, "R8 disabled write ignored", d, 0);

    // main sweep: modes x widths x dividers
    k = 0;
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 2; w++)
        for (int di = 0; di < 3; di++) begin
          tx  = 16'hA5C3 ^ 16'(k * 16'h1357);
          rsp = {tx[6:0], tx[15:7]} ^ 16'h5A0F;
          xfer(m, w[0], (di == 2) ? 5 : di, tx, rsp);
          k++;
        end
    xfer(3, 1'b1, 127, 16'h8001, 16'h7FFE);
    xfer(0, 1'b0, 127, 16'hFF3C, 16'h00C3);

    // R8 write while busy ignored
    bus_write(A_CTL, ctl_word(1, 1'b1, 2, 1'b1, 1'b0, 1'b0));
    arm(1, 1'b1, 16'h1234);
    bus_write(A_DATA, 16'hC0DE);
    bus_write(A_DATA, 16'h0000);
    wait_busy(n, st);
    check(n == 2 * 16 * 3 - 2, "R8 busy write did not restart", n, 2 * 16 * 3 - 2);
    check(cap == 16'hC0DE, "R8 word kept", cap, 16'hC0DE);
    bus_read(A_DATA, d); check(d == 16'h1234, "R8 received kept", d, 16'h1234);

    // R9 abort mid-word
    bus_write(A_CTL, ctl_word(0, 1'b1, 3, 1'b1, 1'b0, 1'b0));
    arm(0, 1'b1, 16'hFFFF);
    bus_write(A_DATA, 16'hFFFF);
    repeat (20) @(negedge clk);
    bus_write(A_CTL, ctl_word(2, 1'b1, 3, 1'b0, 1'b0, 1'b0));
    repeat (2) @(negedge clk);
    #1 check(sclk == 1 && mosi == 0, "R9 lines after abort", {sclk, mosi}, 2);
    bus_read(A_STAT, d); check(d == 16'h0, "R9 status after abort", d, 0);
    repeat (150) @(negedge clk);
    bus_read(A_STAT, d); check(d == 16'h0, "R9 no late completion", d, 0);

    // R10 interrupt sources
    bus_write(A_CTL, ctl_word(0, 1'b0, 0, 1'b1, 1'b1, 1'b0));
    #1 check(irq == 0, "R10 read source idle", irq, 0);
    arm(0, 1'b0, 16'h0042);
    bus_write(A_DATA, 16'h0000);
    wait_busy(n, st);
    #1 check(irq == 1, "R10 read source full", irq, 1);
    bus_read(A_DATA, d);
    #1 check(irq == 0, "R10 read source cleared", irq, 0);
    bus_write(A_CTL, ctl_word(0, 1'b0, 4, 1'b1, 1'b0, 1'b1));
    #1 check(irq == 1, "R10 write source ready", irq, 1);
    arm(0, 1'b0, 16'h0000);
    bus_write(A_DATA, 16'h0011);
    #1 check(irq == 0, "R10 write source busy", irq, 0);
    wait_busy(n, st);
    #1 check(irq == 1, "R10 write source after word", irq, 1);
    bus_write(A_CTL, ctl_word(0, 1'b0, 4, 1'b0, 1'b0, 1'b1));
    #1 check(irq == 0, "R10 write source disabled", irq, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule